// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers interrupt requests from fourteen sources into one pending register, masks them with an enable register, and presents the processor with a 3-bit priority level. Software changes both registers through a single write port. Bit 15 of each written word selects the mode. A 1 in bit 15 sets every bit that is 1 in bits 14:0. A 0 in bit 15 clears every bit that is 1 in bits 14:0. Bits that are 0 in bits 14:0 are left alone in both modes.

Three hardware sources do not go through software writes. Two external timer/IO controllers and a frame-end event each raise a sticky request bit with a one-cycle pulse. The bit stays set until software clears it. Bit 14 of the enable register is a master gate on the output level. Both registers can be read back at any time through a combinational read port. Every port is a plain control or status pin, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both registers read 0x0000 and `irq_level` is 0.
- R2: A write with bit 15 = 1 ORs bits 14:0 into the register chosen by `wr_sel` (0 = enable, 1 = request). The other register is unchanged.
- R3: A write with bit 15 = 0 clears, in the chosen register, every bit that is 1 in bits 14:0. All other bits keep their value.
- R4: `rd_data` shows the register chosen by `rd_sel` (0 = enable, 1 = request) in bits 14:0, in the same cycle. Bit 15 always reads 0.
- R5: `irq_level` is 0 unless enable bit 14 is set and (request AND enable AND 0x3FFF) is nonzero.
- R6: `irq_level` is the highest level that has a pending, enabled bit. The levels are:
  - level 6: bit 13
  - level 5: bits 11–12
  - level 4: bits 7–10
  - level 3: bits 4–6
  - level 2: bit 3
  - level 1: bits 0–2
- R7: A pulse on `ioc_a_pulse` sets request bit 3. A pulse on `ioc_b_pulse` sets request bit 13. A pulse on `frame_end_pulse` sets request bit 5. Each bit stays set with no further pulse until software clears it.
- R8: When a hardware pulse and a software clear of the same request bit occur in the same cycle, the bit ends up set.
- R9: `irq_level` and `rd_data` reflect a write or pulse starting in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = enable, 1 = request |
| wr_data | input | 16 | Write word; bit 15 selects set (1) or clear (0) |
| rd_sel | input | 1 | Read target: 0 = enable, 1 = request |
| rd_data | output | 16 | Selected register, bit 15 reads 0 |
| ioc_a_pulse | input | 1 | First external controller request (sets bit 3) |
| ioc_b_pulse | input | 1 | Second external controller request (sets bit 13) |
| frame_end_pulse | input | 1 | End of last frame line (sets bit 5) |
| irq_level | output | 3 | Processor interrupt priority level, 0 = none |

## Verification
A wrong bit inside either register is visible on `rd_data` in the cycle right after the edge that corrupted it. The same wrong bit also shows on `irq_level` in that cycle whenever it is the highest enabled source. A wrong priority grouping shows up only on `irq_level`, and only when the misplaced bit is the top pending one. For this reason the bench reads both registers and the level after every cycle of a long mixed sequence. It then walks single bits and all level pairs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REQ_W  = 14;
  localparam int REG_W  = 15;
  localparam int WORD_W = 16;
  localparam int LVL_W  = 3;

  localparam int MODE_BIT   = 15;
  localparam int MASTER_BIT = 14;
  localparam int IOA_BIT    = 3;
  localparam int VBL_BIT    = 5;
  localparam int IOB_BIT    = 13;

  localparam int NUM_LVL = 6;

  // Group mask for a level, 1..6.
  function automatic logic [REQ_W-1:0] lvl_mask(input int lvl);
    case (lvl)
      6:       return 14'h2000;
      5:       return 14'h1800;
      4:       return 14'h0780;
      3:       return 14'h0070;
      2:       return 14'h0008;
      1:       return 14'h0007;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         mode_set,
  input  logic [W-1:0] bits,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_next;

  always_comb begin
    sw_next = q;
    if (wr) sw_next = mode_set ? (q | bits) : (q & ~bits);
  end

  // Hardware set overrides a same-cycle software clear.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= sw_next | hw_set;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode_set) |=> ((q & $past(bits)) == $past(bits)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mode_set && hw_set == '0) |=> ((q & $past(bits)) == '0));
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && hw_set == '0) |=> $stable(q));
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_pkg::*;
(
  input  logic [REQ_W-1:0] pend,
  input  logic             master,
  output logic [LVL_W-1:0] level
);
  logic [NUM_LVL:1] hit;

  for (genvar g = 1; g <= NUM_LVL; g++) begin : g_grp
    assign hit[g] = |(pend & lvl_mask(g));
  end

  always_comb begin
    level = '0;
    if (master) begin
      for (int l = 1; l <= NUM_LVL; l++)
        if (hit[l]) level = LVL_W'(l);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ioc_a_pulse,
  input  logic              ioc_b_pulse,
  input  logic              frame_end_pulse,
  output logic [LVL_W-1:0]  irq_level
);
  logic [REG_W-1:0] en_q, req_q, req_hw;
  logic [REQ_W-1:0] pend;

  always_comb begin
    req_hw          = '0;
    req_hw[IOA_BIT] = ioc_a_pulse;
    req_hw[IOB_BIT] = ioc_b_pulse;
    req_hw[VBL_BIT] = frame_end_pulse;
  end

  irq_setclr_reg #(.W(REG_W)) u_en (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_en && !wr_sel), .mode_set(wr_data[MODE_BIT]),
    .bits(wr_data[REG_W-1:0]), .hw_set('0), .q(en_q)
  );

  irq_setclr_reg #(.W(REG_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_en && wr_sel), .mode_set(wr_data[MODE_BIT]),
    .bits(wr_data[REG_W-1:0]), .hw_set(req_hw), .q(req_q)
  );

  assign pend = req_q[REQ_W-1:0] & en_q[REQ_W-1:0];

  irq_level_enc u_enc (
    .pend(pend), .master(en_q[MASTER_BIT]), .level(irq_level)
  );

  assign rd_data = {1'b0, rd_sel ? req_q : en_q};

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[MASTER_BIT] |-> (irq_level == '0));
  p_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[MASTER_BIT] && pend[IOB_BIT]) |-> (irq_level == 3'd6));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_a_pulse |=> req_q[IOA_BIT]);
  p_rd_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[MODE_BIT] == 1'b0);
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ioc_a_pulse = 1'b0, ioc_b_pulse = 1'b0, frame_end_pulse = 1'b0;
  logic [15:0] rd_data;
  logic [2:0]  irq_level;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [14:0] m_en = '0, m_req = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  irq_prio_ctrl dut_i (.*);

  function automatic logic [2:0] exp_lvl(logic [14:0] e, logic [14:0] r);
    logic [13:0] p = e[13:0] & r[13:0];
    if (!e[14] || p == 0) return 3'd0;
    if (p[13])      return 3'd6;
    if (|p[12:11])  return 3'd5;
    if (|p[10:7])   return 3'd4;
    if (|p[6:4])    return 3'd3;
    if (p[3])       return 3'd2;
    return 3'd1;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, update model at posedge, check at next negedge.
  task automatic step(logic w, logic s, logic [15:0] d, logic a, logic b, logic f);
    wr_en = w; wr_sel = s; wr_data = d;
    ioc_a_pulse = a; ioc_b_pulse = b; frame_end_pulse = f;
    @(posedge clk);
    if (w && !s) m_en = d[15] ? (m_en | d[14:0]) : (m_en & ~d[14:0]);
    if (w && s)  m_req = d[15] ? (m_req | d[14:0]) : (m_req & ~d[14:0]);
    m_req[3]  = m_req[3]  | a;
    m_req[13] = m_req[13] | b;
    m_req[5]  = m_req[5]  | f;
    @(negedge clk);
    wr_en = 1'b0; ioc_a_pulse = 1'b0; ioc_b_pulse = 1'b0; frame_end_pulse = 1'b0;
  endtask

  task automatic check_all(string tr, string tl);
    rd_sel = 1'b0; #1 chk(tr, rd_data, {1'b0, m_en});
    rd_sel = 1'b1; #1 chk(tr, rd_data, {1'b0, m_req});
    chk(tl, {13'd0, irq_level}, {13'd0, exp_lvl(m_en, m_req)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1", "R1");

    // R2: set into enable, request untouched
    step(1, 0, 16'hC0F0, 0, 0, 0); check_all("R2", "R2");
    // R3: clear part of enable
    step(1, 0, 16'h0030, 0, 0, 0); check_all("R3", "R3");
    // R9: level reacts the cycle after a request write
    step(1, 1, 16'h8040, 0, 0, 0); check_all("R9", "R9");
    chk("R9", {13'd0, irq_level}, 16'd3);
    // R7: pulses set sticky bits
    step(1, 0, 16'hA008, 0, 0, 0);
    step(0, 0, 16'h0, 1, 0, 1); check_all("R7", "R7");
    repeat (3) step(0, 0, 16'h0, 0, 0, 0);
    check_all("R7", "R7");
    step(0, 0, 16'h0, 0, 1, 0); check_all("R7", "R7");
    chk("R7", {13'd0, irq_level}, 16'd6);
    // R8: clear of bit 3 while pulse sets it
    step(1, 1, 16'h0008, 1, 0, 0); check_all("R8", "R8");
    chk("R8", {15'd0, rd_data[3]}, 16'd1);
    // R5: master off blocks everything
    step(1, 0, 16'h4000, 0, 0, 0); check_all("R5", "R5");
    chk("R5", {13'd0, irq_level}, 16'd0);
    // R4: bit 15 reads zero even after writing all ones
    step(1, 0, 16'hFFFF, 0, 0, 0); check_all("R4", "R4");
    step(1, 1, 16'h7FFF, 0, 0, 0); step(1, 0, 16'h7FFF, 0, 0, 0);

    // R6: single-bit sweep with master on
    for (int i = 0; i < 14; i++) begin
      step(1, 0, 16'h8000 | (16'h4000 | (16'd1 << i)), 0, 0, 0);
      step(1, 1, 16'h8000 | (16'd1 << i), 0, 0, 0);
      check_all("R2", "R6");
      step(1, 1, 16'h7FFF, 0, 0, 0);
      step(1, 0, 16'h7FFF, 0, 0, 0);
    end
    // R6: every pair of bits
    step(1, 0, 16'hFFFF, 0, 0, 0);
    for (int i = 0; i < 14; i++)
      for (int j = i + 1; j < 14; j++) begin
        step(1, 1, 16'h8000 | (16'd1 << i) | (16'd1 << j), 0, 0, 0);
        check_all("R3", "R6");
        step(1, 1, 16'h7FFF, 0, 0, 0);
      end

    // Mixed sweep against the model
    for (int k = 0; k < 3000; k++) begin
      rng = nxt(rng);
      step(rng[0] | rng[1], rng[2], rng[31:16], rng[3] & rng[4] & rng[5],
           rng[6] & rng[7] & rng[8], rng[9] & rng[10] & rng[11]);
      check_all("R4", "R6");
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule